// File: doc/BRIEF.md
# Block Transfer Address and Strobe Sequencer

This block is the master-side sequencer for block transfers on a parallel backplane bus. The bus has already been granted to it. A host-side controller gives it a start address, a beat count, a beat size, a block mode (ordinary block or 64-bit multiplexed block), an address mode (incrementing or fixed) and a byte-swap flag, then pulses `start`. The block then drives the address, the address strobe and the data strobe. It waits for a slave acknowledge or a bus error on every beat, and returns read data with the bytes optionally reversed.

In incrementing mode, a long burst is cut into sub-bursts wherever the next beat address lands on a multiple of the mode's boundary: 256 bytes for ordinary block, 2048 bytes for multiplexed block. At each cut the address strobe goes high for one idle clock and then falls again with the new address. Bus ownership is kept, so no arbitration takes place. Fixed-address mode reads or writes one location repeatedly and never cuts the burst. A request with an illegal size, a misaligned address or a zero count is refused before any strobe moves.

Top module: `blk_burst_seq`

## Requirements
- R1: After reset `as_n` and `ds_n` are 1, and `busy`, `done` and `err` are 0.
- R2: A request is refused when the size does not suit the mode or the count is 0. Sizes are encoded 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit. Ordinary block accepts 1 and 2 only, and multiplexed block accepts 3 only. After a refusal `err` is 1 from the next cycle, while `busy` stays 0 and `as_n` stays 1.
- R3: A request whose start address is not a multiple of the beat size in bytes is refused in the same way as R2.
- R4: In incrementing mode, beat k (counting from 0) is presented at start address + k × beat bytes.
- R5: In ordinary block incrementing mode, `as_n` is high for at least one clock between two beats when the second beat's address is a multiple of 256. At no other point inside a burst does `as_n` rise.
- R6: In multiplexed block incrementing mode, the same rule as R5 applies with a boundary of 2048 bytes.
- R7: In fixed-address mode, every beat uses the start address and `as_n` stays low for the whole burst.
- R8: `as_n` falls one cycle before the first `ds_n` fall. `ds_n` is low only while `as_n` is low. After each acknowledged beat, `ds_n` is high for at least one cycle, and the address is stable while `ds_n` is low.
- R9: `done` pulses for one cycle in the cycle after the last beat is acknowledged. In that same cycle `busy` is 0 and both strobes are high. `err` stays 0 for a completed transfer.
- R10: `bus_err` sampled with `ds_n` low ends the transfer. In the next cycle `err` is 1, `busy` is 0, both strobes are high and `done` is 0.
- R11: `host_rdata` holds the low beat-size bytes of `bus_rdata`. The bytes are in the same order without swap and in reversed order with swap (byte 0 with byte N-1). Bytes above the beat size are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse, accepted while idle |
| req_addr | input | AW | Start byte address |
| req_beats | input | CW | Number of beats |
| req_size | input | 2 | Beat size code (0=8, 1=16, 2=32, 3=64 bits) |
| req_mux | input | 1 | 1 selects multiplexed 64-bit block mode |
| req_fixed | input | 1 | 1 keeps the address fixed |
| req_swap | input | 1 | 1 reverses byte order within each beat |
| bus_ack | input | 1 | Slave acknowledge for the current beat |
| bus_err | input | 1 | Slave bus error for the current beat |
| bus_rdata | input | 64 | Raw data from the bus |
| bus_addr | output | AW | Address driven to the bus |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| host_rdata | output | 64 | Beat data after optional swap |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refusal or bus error, held until the next accepted start |

## Verification
The burst sweep covers every legal mode and size pairing, in both address modes, with start addresses a few beats below a boundary and at zero, and with acknowledge delays of zero and two clocks. Start addresses just below a boundary show whether a cut happens exactly at the boundary address and nowhere else. Starting at zero shows that the first beat is never cut. Fixed mode, run on the same addresses, shows that boundaries are ignored. Illegal size and mode pairs, misaligned addresses and zero counts tell a refusal apart from a started cycle, and an error injected mid-burst shows the abort path separately from normal completion.

// File: rtl/blk_burst_seq.sv
module blk_burst_seq #(
  parameter int AW        = 32,
  parameter int CW        = 12,
  parameter int BLK_SPLIT = 256,
  parameter int MUX_SPLIT = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_beats,
  input  logic [1:0]    req_size,
  input  logic          req_mux,
  input  logic          req_fixed,
  input  logic          req_swap,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [63:0]   bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          as_n,
  output logic          ds_n,
  output logic [63:0]   host_rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int BLK_LG = $clog2(BLK_SPLIT);
  localparam int MUX_LG = $clog2(MUX_SPLIT);

  typedef enum logic [2:0] {S_IDLE, S_AS, S_DS, S_REL, S_GAP} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [1:0]    sz_q;
  logic          mux_q, fix_q, swp_q;

  logic          size_bad, mis_al, req_bad;
  logic [AW-1:0] step, nxt;
  logic          at_bound;

  assign size_bad = req_mux ? (req_size != 2'd3) : (req_size == 2'd0 || req_size == 2'd3);
  assign mis_al   = (req_addr & AW'((4'd1 << req_size) - 4'd1)) != '0;
  assign req_bad  = size_bad || mis_al || (req_beats == '0);

  assign step     = AW'(4'd1 << sz_q);
  assign nxt      = addr_q + step;
  assign at_bound = mux_q ? (nxt[MUX_LG-1:0] == '0) : (nxt[BLK_LG-1:0] == '0);

  assign bus_addr = addr_q;
  assign busy     = (st != S_IDLE);
  assign as_n     = !(st == S_AS || st == S_DS || st == S_REL);
  assign ds_n     = (st != S_DS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      sz_q   <= 2'd0;
      mux_q  <= 1'b0;
      fix_q  <= 1'b0;
      swp_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_bad) begin
            err <= 1'b1;
          end else begin
            err    <= 1'b0;
            addr_q <= req_addr;
            left_q <= req_beats;
            sz_q   <= req_size;
            mux_q  <= req_mux;
            fix_q  <= req_fixed;
            swp_q  <= req_swap;
            st     <= S_AS;
          end
        end
        S_AS:  st <= S_DS;
        S_DS: begin
          if (bus_err) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (bus_ack) begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              if (!fix_q) addr_q <= nxt;
              st <= (!fix_q && at_bound) ? S_GAP : S_REL;
            end
          end
        end
        S_REL: st <= S_DS;
        S_GAP: st <= S_AS;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    int nb;
    nb = 1 << sz_q;
    host_rdata = '0;
    for (int i = 0; i < 8; i++)
      if (i < nb)
        host_rdata[8*i +: 8] = swp_q ? bus_rdata[8*(nb-1-i) +: 8] : bus_rdata[8*i +: 8];
  end

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && req_bad) |=> (err && !busy && as_n));

  assert_ds_inside_as_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> !as_n);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && $past(!ds_n)) |-> $stable(bus_addr));

  assert_no_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n) && !fix_q && bus_addr != $past(bus_addr))
      |-> (mux_q ? (bus_addr[MUX_LG-1:0] != '0) : (bus_addr[BLK_LG-1:0] != '0)));

  assert_fixed_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && fix_q) |-> $stable(bus_addr));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && as_n && !err));
endmodule

// File: tb/blk_burst_seq_test.sv
`timescale 1ns/1ps
module blk_burst_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] req_addr = '0;
  logic [11:0] req_beats = '0;
  logic [1:0]  req_size = '0;
  logic        req_mux = 0, req_fixed = 0, req_swap = 0;
  logic        bus_ack = 0, bus_err = 0;
  logic [63:0] bus_rdata = 64'h8877665544332211;
  logic [31:0] bus_addr;
  logic        as_n, ds_n, busy, done, err;
  logic [63:0] host_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  blk_burst_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .req_beats(req_beats), .req_size(req_size), .req_mux(req_mux), .req_fixed(req_fixed),
    .req_swap(req_swap), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .as_n(as_n), .ds_n(ds_n), .host_rdata(host_rdata),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_data(input int nb, input bit swp);
    logic [63:0] r = '0;
    for (int i = 0; i < nb; i++)
      if (swp) r = (r << 8) | 64'(bus_rdata[8*i +: 8]);
      else     r = r | (64'(bus_rdata[8*i +: 8]) << (8*i));
    return r;
  endfunction

  task automatic refuse(input bit mx, input logic [1:0] sz, input logic [31:0] a, input int n);
    @(negedge clk);
    req_mux = mx; req_size = sz; req_addr = a; req_beats = 12'(n); req_fixed = 0; start = 1;
    @(negedge clk); start = 0;
    chk(err == 1 && busy == 0 && as_n == 1, "R2/R3 refuse", {err, busy, as_n}, 3'b101);
    @(negedge clk);
    chk(as_n == 1 && ds_n == 1 && busy == 0, "R2/R3 no cycle", {as_n, ds_n, busy}, 3'b110);
  endtask

  task automatic run(input bit mx, input logic [1:0] sz, input bit fx, input bit sw,
                     input logic [31:0] a0, input int n, input int dly, input int ebeat);
    int nb = 1 << sz;
    int bound = mx ? 2048 : 256;
    int k = 0, w = 0;
    bit gap = 0, acked = 0, errd = 0, fin = 0;
    logic [31:0] ea;
    @(negedge clk);
    req_mux = mx; req_size = sz; req_fixed = fx; req_swap = sw;
    req_addr = a0; req_beats = 12'(n); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !as_n && ds_n && !err, "R8 AS before DS", {busy, as_n, ds_n, err}, 4'b1010);
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      @(negedge clk);
      bus_ack = 0; bus_err = 0;
      if (errd) begin
        chk(err && !busy && as_n && ds_n && !done, "R10 abort", {err, busy, as_n, ds_n, done}, 5'b10110);
        fin = 1;
      end else if (acked && k == n) begin
        chk(done && !busy && as_n && ds_n && !err, "R9 done", {done, busy, as_n, ds_n, err}, 5'b10110);
        @(negedge clk);
        chk(!done, "R9 one-cycle pulse", done, 0);
        fin = 1;
      end else begin
        if (acked) chk(ds_n == 1, "R8 DS release", ds_n, 1);
        acked = 0;
        if (as_n) gap = 1;
        if (!ds_n) begin
          ea = fx ? a0 : a0 + 32'(k * nb);
          if (w == 0) begin
            chk(bus_addr == ea, fx ? "R7 fixed addr" : "R4 addr", bus_addr, ea);
            if (k > 0)
              chk(gap == (!fx && (ea % bound) == 0), fx ? "R7 no split" : (mx ? "R6 split" : "R5 split"),
                  gap, (!fx && (ea % bound) == 0));
            gap = 0;
          end
          if (w == dly) begin
            if (k == ebeat) begin bus_err = 1; errd = 1; end
            else begin
              bus_ack = 1; acked = 1;
              #1 chk(host_rdata == exp_data(nb, sw), "R11 data", host_rdata, exp_data(nb, sw));
            end
            k++; w = 0;
          end else w++;
        end
      end
    end
    chk(fin, "watchdog", fin, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(as_n && ds_n && !busy && !done && !err, "R1 reset", {as_n, ds_n, busy, done, err}, 5'b11000);
    rst_n = 1;
    for (int mx = 0; mx < 2; mx++)
      for (int s = 1; s < 4; s++) begin
        if ((mx == 1) != (s == 3)) continue;
        for (int fx = 0; fx < 2; fx++)
          for (int d = 0; d < 3; d += 2) begin
            run(mx[0], 2'(s), fx[0], d[0] ^ fx[0], 32'((mx ? 2048 : 256) * 3 - 3 * (1 << s)), 7, d, 99);
            run(mx[0], 2'(s), fx[0], ~fx[0], 32'h0, 4, d, 99);
          end
      end
    run(0, 2'd2, 0, 0, 32'h1F8, 6, 1, 3);
    run(1, 2'd3, 0, 1, 32'h7F0, 5, 0, 2);
    for (int s = 0; s < 4; s++) begin
      if (s == 0 || s == 3) refuse(0, 2'(s), 32'h100, 4);
      if (s != 3) refuse(1, 2'(s), 32'h800, 4);
    end
    refuse(0, 2'd1, 32'h101, 4);
    refuse(0, 2'd2, 32'h102, 4);
    refuse(1, 2'd3, 32'h804, 4);
    refuse(0, 2'd2, 32'h100, 0);
    run(0, 2'd1, 0, 0, 32'h10, 2, 0, 99);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule